// File: doc/BRIEF.md
# SDRAM Power-up and Refresh Sequencer

This block brings a single-data-rate SDRAM from power-on into service and then keeps it refreshed. Out of reset it holds the command bus idle for a fixed settling period. It then closes all banks and lets the refresh timer, running at a short start-up rate, pace a fixed number of auto-refresh commands. After those it programs the device mode register with burst length 8 and CAS latency 3. Burst 8 is needed because a host burst of four 32-bit words becomes eight transfers on a 16-bit device. After that it raises `ready` and issues auto-refresh on its own at the slower run-time interval.

Every spacing between commands comes from timing inputs that use an n+1 encoding: a value n means the next command may follow n+1 clocks later. The refresh interval inputs count in units of 16 clocks. During normal operation another agent that owns the command bus can raise `bus_busy`. A refresh that falls due then is kept pending and is issued once the bus is free. Read and write transfers, mapping of user addresses, and power-down modes belong to other blocks.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is high, the bus shows NOP (chip select low, RAS/CAS/WE high), the address is zero and `ready` is low.
- R2: The first command after reset is precharge-all. It appears on the NOP_CYCLES-th clock after reset falls, with address bit 10 high and every other address bit low.
- R3: Chip select is low in every cycle after reset. RAS/CAS/WE encode NOP=111, precharge=010, auto-refresh=001 and load-mode=000. Every command other than NOP lasts exactly one cycle.
- R4: During start-up the refresh interval is fixed at 2 units (32 clocks). The first auto-refresh comes 34 clocks after precharge-all. Each later start-up refresh comes 32 clocks after the one before it.
- R5: Exactly INIT_REFS (default 8) start-up refreshes are issued. Load-mode follows them and is issued once. It carries the mode word 0x33 on the address bus: burst code 3 (burst 8) in bits 2:0 and CAS latency 3 in bits 6:4.
- R6: A timing input n gives exactly n+1 clocks from one command to the next. This holds for precharge-all wait (`cfg_trp`), refresh wait (`cfg_trfc`) and mode wait (`cfg_tmrd`), including n = 0.
- R7: `ready` rises exactly `cfg_tmrd`+1 clocks after load-mode and stays high until reset.
- R8: After load-mode the interval switches to `cfg_refi` (n ≥ 1) × 16 clocks. The first run-time refresh comes n×16+2 clocks after load-mode, and each later one comes n×16 clocks after the one before it.
- R9: In normal operation no refresh is issued in the cycle after one in which `bus_busy` was high. A refresh that falls due while the bus is busy is kept and issued one clock after `bus_busy` falls. The interval timer keeps its original phase.
- R10: At least 128 clocks pass between precharge-all and load-mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_trp | input | TIM_W | Precharge-all to next command, n+1 clocks |
| cfg_trfc | input | TIM_W | Auto-refresh to next command, n+1 clocks |
| cfg_tmrd | input | TIM_W | Load-mode to ready, n+1 clocks |
| cfg_refi | input | REFI_W | Run-time refresh interval in units of 16 clocks |
| bus_busy | input | 1 | Another agent holds the command bus; defers refresh |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus: bit 10 for precharge-all, mode word for load-mode |
| ready | output | 1 | Start-up complete |

## Verification
A wrong state register or wait count shows up at the next command the bus issues. It shows as the wrong command code or as a gap between commands that is off by one or more clocks. The scoreboard measures every gap from the previous command, so such an error is reported within one refresh interval at most. A wrong start-up refresh count shows as load-mode arriving early or late, or as an extra refresh. A refresh request that is lost or duplicated shows as a gap after the `bus_busy` window that differs from the expected 16-clock shift. A wrong rate switch shows as the first run-time gap differing from n×16+2.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [2:0] {
        CMD_LMR  = 3'b000,
        CMD_REF  = 3'b001,
        CMD_PALL = 3'b010,
        CMD_NOP  = 3'b111
    } sdr_cmd_e;

    typedef struct packed {
        logic     cs_n;
        sdr_cmd_e op;
    } sdr_bus_t;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PALL,
        ST_PALL_WAIT,
        ST_INIT_IDLE,
        ST_INIT_REF,
        ST_IREF_WAIT,
        ST_LMR,
        ST_LMR_WAIT,
        ST_RUN,
        ST_RUN_REF,
        ST_RREF_WAIT
    } seq_state_e;

    localparam int          AP_BIT   = 10;
    localparam logic [2:0]  BL8_CODE = 3'd3;
    localparam logic [2:0]  CAS3     = 3'd3;

    // Mode register layout: burst code [2:0], burst type [3], CAS latency [6:4]
    function automatic logic [11:0] sdr_mode_word(input logic [2:0] bl_code,
                                                  input logic [2:0] cas_lat);
        return {5'b0, cas_lat, 1'b0, bl_code};
    endfunction

    function automatic logic in_service(input seq_state_e s);
        return (s == ST_RUN) || (s == ST_RUN_REF) || (s == ST_RREF_WAIT);
    endfunction

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int TIM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TIM_W-1:0] load_val,
    output logic             last
);
    logic [TIM_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - TIM_W'(1);
    end

    assign last = (cnt == TIM_W'(1));
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
    parameter int REFI_W    = 12,
    parameter int INIT_REFI = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              use_run,
    input  logic [REFI_W-1:0] refi_run,
    input  logic              taken,
    output logic              pending
);
    localparam int CW = REFI_W + 4;

    logic [CW-1:0] cnt;
    logic [CW-1:0] period;
    logic          wrap;

    always_comb begin
        if (use_run) period = {refi_run, 4'b0000};
        else         period = CW'(INIT_REFI) << 4;
        wrap = (cnt == period - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            cnt <= wrap ? '0 : cnt + CW'(1);
            if (wrap)       pending <= 1'b1;
            else if (taken) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive
    import sdr_seq_pkg::*;
#(
    parameter int          ADDR_W = 13,
    parameter logic [11:0] MODE   = 12'h033
) (
    input  seq_state_e        state,
    output sdr_bus_t          bus,
    output logic [ADDR_W-1:0] addr
);
    always_comb begin
        bus.cs_n = 1'b0;
        bus.op   = CMD_NOP;
        addr     = '0;
        unique case (state)
            ST_PALL: begin
                bus.op       = CMD_PALL;
                addr[AP_BIT] = 1'b1;
            end
            ST_INIT_REF, ST_RUN_REF: bus.op = CMD_REF;
            ST_LMR: begin
                bus.op = CMD_LMR;
                addr   = ADDR_W'(MODE);
            end
            default: bus.op = CMD_NOP;
        endcase
    end
endmodule

// File: rtl/sdram_boot_seq.sv
module sdram_boot_seq
    import sdr_seq_pkg::*;
#(
    parameter int         NOP_CYCLES = 25000,
    parameter int         TIM_W      = 4,
    parameter int         REFI_W     = 12,
    parameter int         ADDR_W     = 13,
    parameter int         INIT_REFI  = 2,
    parameter int         INIT_REFS  = 8,
    parameter logic [2:0] BURST_CODE = BL8_CODE,
    parameter logic [2:0] CAS_LAT    = CAS3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [TIM_W-1:0]  cfg_trp,
    input  logic [TIM_W-1:0]  cfg_trfc,
    input  logic [TIM_W-1:0]  cfg_tmrd,
    input  logic [REFI_W-1:0] cfg_refi,
    input  logic              bus_busy,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              ready
);
    localparam int          NOP_W = $clog2(NOP_CYCLES + 1);
    localparam int          RC_W  = $clog2(INIT_REFS + 1);
    localparam logic [11:0] MODE  = sdr_mode_word(BURST_CODE, CAS_LAT);

    seq_state_e        state, nxt;
    logic [NOP_W-1:0]  nop_cnt;
    logic [RC_W-1:0]   ref_cnt;
    logic              rate_run;
    logic              tmr_load, tmr_last;
    logic [TIM_W-1:0]  tmr_val;
    logic              ref_pend, ref_taken, ref_restart;
    sdr_bus_t          bus;

    // Wait length loaded on each command cycle
    always_comb begin
        tmr_load = 1'b1;
        tmr_val  = '0;
        unique case (state)
            ST_PALL:                 tmr_val = cfg_trp;
            ST_INIT_REF, ST_RUN_REF: tmr_val = cfg_trfc;
            ST_LMR:                  tmr_val = cfg_tmrd;
            default:                 tmr_load = 1'b0;
        endcase
    end

    sdr_wait_timer #(.TIM_W(TIM_W)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    assign ref_taken   = (state == ST_INIT_REF) || (state == ST_RUN_REF);
    assign ref_restart = (state == ST_PALL) || (state == ST_LMR);

    sdr_refresh_timer #(.REFI_W(REFI_W), .INIT_REFI(INIT_REFI)) u_refi (
        .clk      (clk),
        .rst      (rst),
        .restart  (ref_restart),
        .use_run  (rate_run),
        .refi_run (cfg_refi),
        .taken    (ref_taken),
        .pending  (ref_pend)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_POWERUP:   if (nop_cnt == '0) nxt = ST_PALL;
            ST_PALL:      nxt = (cfg_trp == '0) ? ST_INIT_IDLE : ST_PALL_WAIT;
            ST_PALL_WAIT: if (tmr_last) nxt = ST_INIT_IDLE;
            ST_INIT_IDLE: if (ref_pend) nxt = ST_INIT_REF;
            ST_INIT_REF: begin
                if (cfg_trfc != '0)
                    nxt = ST_IREF_WAIT;
                else if (ref_cnt == RC_W'(INIT_REFS - 1))
                    nxt = ST_LMR;
                else
                    nxt = ST_INIT_IDLE;
            end
            ST_IREF_WAIT: if (tmr_last)
                nxt = (ref_cnt == RC_W'(INIT_REFS)) ? ST_LMR : ST_INIT_IDLE;
            ST_LMR:       nxt = (cfg_tmrd == '0) ? ST_RUN : ST_LMR_WAIT;
            ST_LMR_WAIT:  if (tmr_last) nxt = ST_RUN;
            ST_RUN:       if (ref_pend && !bus_busy) nxt = ST_RUN_REF;
            ST_RUN_REF:   nxt = (cfg_trfc == '0) ? ST_RUN : ST_RREF_WAIT;
            ST_RREF_WAIT: if (tmr_last) nxt = ST_RUN;
            default:      nxt = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_POWERUP;
            nop_cnt  <= NOP_W'(NOP_CYCLES - 1);
            ref_cnt  <= '0;
            rate_run <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_POWERUP && nop_cnt != '0) nop_cnt <= nop_cnt - NOP_W'(1);
            if (state == ST_INIT_REF)                 ref_cnt <= ref_cnt + RC_W'(1);
            if (state == ST_LMR)                      rate_run <= 1'b1;
        end
    end

    sdr_cmd_drive #(.ADDR_W(ADDR_W), .MODE(MODE)) u_drive (
        .state (state),
        .bus   (bus),
        .addr  (sd_addr)
    );

    assign sd_cs_n                       = bus.cs_n;
    assign {sd_ras_n, sd_cas_n, sd_we_n} = bus.op;
    assign ready                         = in_service(state);
endmodule

// File: rtl/sdr_seq_checker.sv
module sdr_seq_checker #(
    parameter int ADDR_W     = 13,
    parameter int TIM_W      = 4,
    parameter int INIT_REFS  = 8,
    parameter int MIN_SETTLE = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              ready,
    input logic              bus_busy,
    input logic [TIM_W-1:0]  cfg_trfc
);
    logic [2:0]   op;
    logic         is_ref, is_pall, is_lmr, is_nop;
    logic [7:0]   init_refs;
    logic [15:0]  since_pall;
    logic         pall_seen, lmr_seen, ref_seen;
    logic [TIM_W:0] since_ref;

    assign op      = {ras_n, cas_n, we_n};
    assign is_ref  = (op == 3'b001);
    assign is_pall = (op == 3'b010);
    assign is_lmr  = (op == 3'b000);
    assign is_nop  = (op == 3'b111);

    always_ff @(posedge clk) begin
        if (rst) begin
            init_refs  <= '0;
            since_pall <= '0;
            pall_seen  <= 1'b0;
            lmr_seen   <= 1'b0;
            ref_seen   <= 1'b0;
            since_ref  <= '0;
        end else begin
            if (is_ref && !ready && init_refs != 8'hFF) init_refs <= init_refs + 8'd1;
            if (is_pall) begin
                pall_seen  <= 1'b1;
                since_pall <= 16'd1;
            end else if (since_pall != 16'hFFFF) begin
                since_pall <= since_pall + 16'd1;
            end
            if (is_lmr) lmr_seen <= 1'b1;
            if (is_ref) begin
                ref_seen  <= 1'b1;
                since_ref <= (TIM_W+1)'(1);
            end else if (since_ref != '1) begin
                since_ref <= since_ref + (TIM_W+1)'(1);
            end
        end
    end

    p_cs_low_r3: assert property (@(posedge clk) disable iff (rst) !cs_n);
    p_pall_a10_r2: assert property (@(posedge clk) disable iff (rst) is_pall |-> addr[10]);
    p_lmr_after_refs_r5: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (init_refs == 8'(INIT_REFS)));
    p_lmr_once_r5: assert property (@(posedge clk) disable iff (rst) is_lmr |-> !lmr_seen);
    p_settle_r10: assert property (@(posedge clk) disable iff (rst)
        is_lmr |-> (pall_seen && since_pall >= 16'(MIN_SETTLE)));
    p_ready_hold_r7: assert property (@(posedge clk) disable iff (rst) ready |=> ready);
    p_ready_after_lmr_r7: assert property (@(posedge clk) disable iff (rst) ready |-> lmr_seen);
    p_busy_defers_r9: assert property (@(posedge clk) disable iff (rst)
        (ready && $past(bus_busy)) |-> !is_ref);
    p_ref_spacing_r6: assert property (@(posedge clk) disable iff (rst)
        (!is_nop && ref_seen) |-> (since_ref > {1'b0, cfg_trfc}));
endmodule

bind sdram_boot_seq sdr_seq_checker #(
    .ADDR_W    (ADDR_W),
    .TIM_W     (TIM_W),
    .INIT_REFS (INIT_REFS)
) u_seq_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (sd_cs_n),
    .ras_n    (sd_ras_n),
    .cas_n    (sd_cas_n),
    .we_n     (sd_we_n),
    .addr     (sd_addr),
    .ready    (ready),
    .bus_busy (bus_busy),
    .cfg_trfc (cfg_trfc)
);

// File: tb/test_sdram_boot_seq.sv
`timescale 1ns/1ps
module test_sdram_boot_seq;

    localparam int NOPC = 40;
    localparam int AW   = 13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    cfg_trp = '0, cfg_trfc = '0, cfg_tmrd = '0;
    logic [11:0]   cfg_refi = 12'd1;
    logic          bus_busy = 1'b0;
    logic          sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready;
    logic [AW-1:0] sd_addr;

    always #4 clk = ~clk;

    sdram_boot_seq #(.NOP_CYCLES(NOPC), .ADDR_W(AW)) i_sdram_boot_seq (
        .clk(clk), .rst(rst),
        .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc), .cfg_tmrd(cfg_tmrd), .cfg_refi(cfg_refi),
        .bus_busy(bus_busy),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_addr(sd_addr), .ready(ready)
    );

    typedef struct {
        logic [2:0]    op;
        int            gap;
        logic [AW-1:0] addr;
        string         req;
    } exp_t;

    exp_t sb[$];
    int   n_tests = 0;
    int   n_fail  = 0;
    int   sample  = 0;
    int   last_cmd = 0;
    int   lmr_at   = 0;
    bit   lmr_seen = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [2:0] op, input int gap, input logic [AW-1:0] addr,
                        input string req);
        exp_t e;
        e.op = op; e.gap = gap; e.addr = addr; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: pops expected commands and compares them as they appear
    always @(negedge clk) begin
        if (rst) begin
            sample = 0; last_cmd = 0; lmr_seen = 0; lmr_at = 0;
        end else begin
            logic [2:0] op;
            bit exp_ready;
            sample = sample + 1;
            op = {sd_ras_n, sd_cas_n, sd_we_n};
            check(sd_cs_n == 1'b0, "R3", "chip select", int'(sd_cs_n), 0);
            exp_ready = lmr_seen && ((sample - lmr_at) > int'(cfg_tmrd));
            check(ready == exp_ready, "R7", "ready", int'(ready), int'(exp_ready));
            if (op != 3'b111) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3", "unexpected command", int'(op), 7);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(op == e.op, e.req, "command code", int'(op), int'(e.op));
                    check(sample - last_cmd == e.gap, e.req, "gap in clocks",
                          sample - last_cmd, e.gap);
                    check(sd_addr == e.addr, e.req, "address", int'(sd_addr), int'(e.addr));
                end
                last_cmd = sample;
                if (op == 3'b000) begin
                    lmr_seen = 1;
                    lmr_at   = sample;
                end
            end
        end
    end

    task automatic wait_until(input int target);
        do begin
            @(negedge clk); #1;
        end while (sample < target);
    endtask

    task automatic drain();
        while (sb.size() != 0) begin
            @(negedge clk); #1;
        end
        repeat (4) @(negedge clk);
        #1;
    endtask

    task automatic scenario(input int trp, input int trfc, input int tmrd, input int refi,
                            input bit do_busy);
        int p;
        int base;
        p = refi * 16;
        @(negedge clk); #1;
        rst = 1'b1; bus_busy = 1'b0;
        cfg_trp = 4'(trp); cfg_trfc = 4'(trfc); cfg_tmrd = 4'(tmrd); cfg_refi = 12'(refi);
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "bus in reset",
              int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
        check(ready == 1'b0, "R1", "ready in reset", int'(ready), 0);
        check(sd_addr == '0, "R1", "address in reset", int'(sd_addr), 0);
        push(3'b010, NOPC, AW'(1) << 10, "R2");
        push(3'b001, 34, '0, "R4");
        for (int i = 0; i < 7; i++) push(3'b001, 32, '0, "R4");
        push(3'b000, trfc + 1, AW'(12'h033), "R5");
        push(3'b001, p + 2, '0, "R8");
        push(3'b001, p, '0, "R8");
        push(3'b001, p, '0, "R8");
        rst = 1'b0;
        drain();
        if (do_busy) begin
            base = last_cmd;
            wait_until(base + p - 10);
            bus_busy = 1'b1;
            push(3'b001, p + 16, '0, "R9");
            push(3'b001, p - 16, '0, "R9");
            wait_until(base + p + 15);
            bus_busy = 1'b0;
            drain();
        end
    endtask

    initial begin
        scenario(2, 6, 3, 5, 1'b1);   // R6 nonzero waits, R9 deferral
        scenario(0, 0, 0, 3, 1'b0);   // R6 zero waits
        check(sb.size() == 0, "R5", "pending expectations", sb.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule